// File: doc/BRIEF.md
# APB Real-Time Clock with Alarm

This block keeps a 32-bit count of elapsed seconds and raises an interrupt when that count reaches a programmed alarm value. A prescaler divides the system clock down to one tick per second, and the count advances by one on each tick. The count runs freely and wraps modulo 2^32. Software never stops the count. It rebases the count by writing a new value, and it arms the alarm by writing a match value.

Registers are reached over an APB slave port with zero wait states and a 4 KB window. A raw alarm flag is set either on the tick where the count lands on the match value, or at once when a write makes the two equal. A one-bit mask gates that flag onto a level interrupt. Writing any value to the clear location drops the flag. Eight identification bytes occupy the top words of the window so that driver code can probe for the block.

Top module: `rtc_apb_alarm`

## Requirements
- R1: After reset the count, match value, last loaded value, mask and raw flag all read 0, and irq is low.
- R2: With no writes, the count read at offset 0x00 increases by exactly one every CLK_HZ clock cycles.
- R3: A write to offset 0x08 sets the count to the written value on that cycle and restarts the prescaler, so the next increment comes CLK_HZ cycles after the write. Reads of 0x08 return the last value written there.
- R4: The count wraps from 0xFFFFFFFF to 0. A match value below the current count fires once the count has wrapped and reached it.
- R5: A write to the match register (0x04) or the load register (0x08) that leaves count and match equal sets the raw flag (offset 0x14, bit 0) in that same write cycle.
- R6: With no writes, the raw flag is set on the tick where the count becomes equal to the match value.
- R7: The mask register (0x10) keeps only bit 0. The irq output and the masked status read at 0x18 both equal raw flag AND mask.
- R8: A write of any data to offset 0x1C clears the raw flag. A read of 0x1C returns 0.
- R9: The control location (0x0C) always reads 1, and writes to it change nothing.
- R10: Writes to 0x00, 0x14 and 0x18 are ignored. Undefined offsets read 0.
- R11: Offsets 0xFE0 to 0xFFC read one identification byte per word, in this order: 0x31, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; also the source of the seconds tick |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | APB slave select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | 12 | Byte address inside the 4 KB window |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Always 1: no wait states |
| irq | output | 1 | Level interrupt, raw flag AND mask |

## Verification
The count is loaded and then read back on the cycles just before and just after the first expected tick. This separates a prescaler that restarts on load from one that runs on, and it catches an off-by-one in the divider. The alarm is driven three ways, and each way points to a different cause if it fails. In the first, a match one above the count must wait for a tick. In the second, a match or load equal to the count must fire at once. In the third, a match of 0 against a count of 0xFFFFFFFF shows whether the compare follows the wrap. Writes to read-only and control locations, masks with stray upper bits, and clear writes carrying zero data show that only the intended state moves.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 12;

    // Word index of each location in the low part of the window (paddr[4:2]).
    typedef enum logic [2:0] {
        REG_COUNT   = 3'd0,
        REG_MATCH   = 3'd1,
        REG_LOAD    = 3'd2,
        REG_CTRL    = 3'd3,
        REG_MASK    = 3'd4,
        REG_RAW     = 3'd5,
        REG_MASKED  = 3'd6,
        REG_CLEAR   = 3'd7
    } rtc_reg_e;

    // Write strobes after address decode.
    typedef struct packed {
        logic load;
        logic match;
        logic mask;
        logic clear;
    } rtc_wr_s;

    // The low window covers 0x000..0x01F; the ID window covers 0xFE0..0xFFF.
    function automatic logic in_reg_window(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:5] == '0;
    endfunction

    function automatic logic in_id_window(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:5] == '1;
    endfunction

    function automatic logic [7:0] id_byte(input logic [2:0] idx);
        logic [7:0] b;
        case (idx)
            3'd0:    b = 8'h31;
            3'd1:    b = 8'h10;
            3'd2:    b = 8'h14;
            3'd3:    b = 8'h00;
            3'd4:    b = 8'h0D;
            3'd5:    b = 8'hF0;
            3'd6:    b = 8'h05;
            default: b = 8'hB1;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int CLK_HZ = 50_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic tick
);
    localparam int DIV = (CLK_HZ < 1) ? 1 : CLK_HZ;
    localparam int CW  = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] TERM = CW'(DIV - 1);

    logic [CW-1:0] div_q;

    // A restart wins over a pending tick, so a load always starts a full second.
    assign tick = (div_q == TERM) && !restart;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            div_q <= '0;
        end else if (tick) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    generate
        if (DIV > 1) begin : g_chk
            // R2: ticks never arrive on back-to-back cycles
            a_r2_tick_gap: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick);
            // R3: the cycle after a restart never carries a tick
            a_r3_restart_delays: assert property (@(posedge clk) disable iff (rst)
                restart |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/rtc_timebase.sv
module rtc_timebase
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              load_en,
    input  logic [DATA_W-1:0] load_val,
    output logic [DATA_W-1:0] count_q,
    output logic [DATA_W-1:0] count_nxt,
    output logic [DATA_W-1:0] loaded_q
);

    always_comb begin
        if (load_en) begin
            count_nxt = load_val;
        end else if (tick) begin
            count_nxt = count_q + 1'b1;   // wraps modulo 2^DATA_W
        end else begin
            count_nxt = count_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q  <= '0;
            loaded_q <= '0;
        end else begin
            count_q <= count_nxt;
            if (load_en) begin
                loaded_q <= load_val;
            end
        end
    end

    // R3: a load lands in the count on the next edge
    a_r3_load_lands: assert property (@(posedge clk) disable iff (rst)
        load_en |=> (count_q == $past(load_val)));
    // R2: a tick without a load advances by one
    a_r2_step_one: assert property (@(posedge clk) disable iff (rst)
        (tick && !load_en) |=> (count_q == $past(count_q) + 1'b1));
    // R4: all-ones rolls over to zero
    a_r4_wrap_zero: assert property (@(posedge clk) disable iff (rst)
        (tick && !load_en && (count_q == '1)) |=> (count_q == '0));
    // R2: without tick or load the count holds
    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        (!tick && !load_en) |=> $stable(count_q));

endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  rtc_wr_s           wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] count_q,
    input  logic [DATA_W-1:0] count_nxt,
    output logic [DATA_W-1:0] match_q,
    output logic              mask_q,
    output logic              raw_q
);

    logic [DATA_W-1:0] match_nxt;
    logic              event_any;
    logic              hit;

    assign match_nxt = wr.match ? wdata : match_q;
    // Compare only when the count or the match value is about to change, so
    // an equal pair left over from earlier does not fire again.
    assign event_any = tick || wr.match || wr.load;
    assign hit       = event_any && (count_nxt == match_nxt);

    always_ff @(posedge clk) begin
        if (rst) begin
            match_q <= '0;
            mask_q  <= 1'b0;
            raw_q   <= 1'b0;
        end else begin
            match_q <= match_nxt;
            if (wr.mask) begin
                mask_q <= wdata[0];
            end
            // A new hit takes priority over a clear in the same cycle.
            if (hit) begin
                raw_q <= 1'b1;
            end else if (wr.clear) begin
                raw_q <= 1'b0;
            end
        end
    end

    // R5 R6: the flag only rises with count and match equal
    a_r6_rise_equal: assert property (@(posedge clk) disable iff (rst)
        $rose(raw_q) |-> (count_q == match_q));
    // R5: a match write equal to the coming count sets the flag
    a_r5_match_now: assert property (@(posedge clk) disable iff (rst)
        (wr.match && (wdata == count_nxt)) |=> raw_q);
    // R8: a clear with no new hit drops the flag
    a_r8_clear_drops: assert property (@(posedge clk) disable iff (rst)
        (wr.clear && !event_any) |=> !raw_q);
    // R7: the mask stores only bit 0 of the written data
    a_r7_mask_bit0: assert property (@(posedge clk) disable iff (rst)
        wr.mask |=> (mask_q == $past(wdata[0])));

endmodule

// File: rtl/rtc_apb_alarm.sv
module rtc_apb_alarm
    import rtc_pkg::*;
#(
    parameter int CLK_HZ = 50_000_000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              pready,
    output logic              irq
);

    rtc_reg_e          idx;
    logic              wr_cycle;
    rtc_wr_s           wr;
    logic              tick;
    logic [DATA_W-1:0] count_q;
    logic [DATA_W-1:0] count_nxt;
    logic [DATA_W-1:0] loaded_q;
    logic [DATA_W-1:0] match_q;
    logic              mask_q;
    logic              raw_q;
    logic              masked;
    logic              unused_addr_lsb;

    assign pready          = 1'b1;
    assign unused_addr_lsb = ^paddr[1:0];
    assign idx             = rtc_reg_e'(paddr[4:2]);
    assign wr_cycle        = psel && penable && pwrite && in_reg_window(paddr);

    // Only four locations have write side effects; the rest drop the data.
    always_comb begin
        wr       = '0;
        wr.load  = wr_cycle && (idx == REG_LOAD);
        wr.match = wr_cycle && (idx == REG_MATCH);
        wr.mask  = wr_cycle && (idx == REG_MASK);
        wr.clear = wr_cycle && (idx == REG_CLEAR);
    end

    rtc_prescaler #(
        .CLK_HZ (CLK_HZ)
    ) u_prescaler (
        .clk     (clk),
        .rst     (rst),
        .restart (wr.load),
        .tick    (tick)
    );

    rtc_timebase u_timebase (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .load_en   (wr.load),
        .load_val  (pwdata),
        .count_q   (count_q),
        .count_nxt (count_nxt),
        .loaded_q  (loaded_q)
    );

    rtc_alarm u_alarm (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .wr        (wr),
        .wdata     (pwdata),
        .count_q   (count_q),
        .count_nxt (count_nxt),
        .match_q   (match_q),
        .mask_q    (mask_q),
        .raw_q     (raw_q)
    );

    assign masked = raw_q && mask_q;
    assign irq    = masked;

    always_comb begin
        prdata = '0;
        if (in_id_window(paddr)) begin
            prdata = {{(DATA_W-8){1'b0}}, id_byte(paddr[4:2])};
        end else if (in_reg_window(paddr)) begin
            case (idx)
                REG_COUNT:  prdata = count_q;
                REG_MATCH:  prdata = match_q;
                REG_LOAD:   prdata = loaded_q;
                REG_CTRL:   prdata = {{(DATA_W-1){1'b0}}, 1'b1};
                REG_MASK:   prdata = {{(DATA_W-1){1'b0}}, mask_q};
                REG_RAW:    prdata = {{(DATA_W-1){1'b0}}, raw_q};
                REG_MASKED: prdata = {{(DATA_W-1){1'b0}}, masked};
                default:    prdata = '0;
            endcase
        end
    end

    // R7: the interrupt can only rise while the mask is set
    a_r7_irq_needs_mask: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> mask_q);
    // R8: a clear write with the count idle leaves the interrupt low
    a_r8_clear_irq: assert property (@(posedge clk) disable iff (rst)
        (wr.clear && !tick) |=> !irq);

endmodule

// File: tb/rtc_apb_alarm_tb_top.sv
module rtc_apb_alarm_tb_top;

    localparam int HZ = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        psel = 1'b0;
    logic        penable = 1'b0;
    logic        pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready;
    logic        irq;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    logic [31:0] exp_q[$];
    logic [11:0] adr_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;   // 200 MHz

    rtc_apb_alarm #(.CLK_HZ(HZ)) dut_i (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready), .irq(irq)
    );

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic apb_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    // Driver: queues the expected data; the monitor compares it in the access phase.
    task automatic apb_read(input logic [11:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
        @(negedge clk);
        exp_q.push_back(e); adr_q.push_back(a); tag_q.push_back(tag);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic check_irq(input logic e, input string tag);
        #1;
        checks++;
        if (irq !== e) begin
            failures++;
            $display("FAIL %s irq actual=%0b expected=%0b", tag, irq, e);
        end
    endtask

    // Monitor
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (psel && penable && !pwrite) begin
                checks++;
                if (exp_q.size() == 0) begin
                    failures++;
                    $display("FAIL scoreboard read with no expectation actual=%h expected=none", prdata);
                end else begin
                    logic [31:0] e;
                    logic [11:0] a;
                    string t;
                    e = exp_q.pop_front(); a = adr_q.pop_front(); t = tag_q.pop_front();
                    if (prdata !== e || pready !== 1'b1) begin
                        failures++;
                        $display("FAIL %s addr=%h actual=%h expected=%h", t, a, prdata, e);
                    end
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        apb_read(12'h000, 32'h0, "R1 count");
        apb_read(12'h004, 32'h0, "R1 match");
        apb_read(12'h008, 32'h0, "R1 loaded");
        apb_read(12'h010, 32'h0, "R1 mask");
        apb_read(12'h014, 32'h0, "R1 raw");
        apb_read(12'h018, 32'h0, "R1 masked");
        check_irq(1'b0, "R1");

        // R11 identification bytes
        begin
            logic [7:0] ids [8] = '{8'h31, 8'h10, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
            for (int i = 0; i < 8; i++) begin
                apb_read(12'hFE0 + 12'(i * 4), {24'h0, ids[i]}, "R11 id");
            end
        end

        // R9 control fixed, R10 undefined offsets read zero, R8 clear reads zero
        apb_write(12'h00C, 32'h0);
        apb_read(12'h00C, 32'h1, "R9 ctrl");
        apb_read(12'h020, 32'h0, "R10 undefined 0x020");
        apb_read(12'h800, 32'h0, "R10 undefined 0x800");
        apb_read(12'hFDC, 32'h0, "R10 undefined 0xFDC");
        apb_read(12'h01C, 32'h0, "R8 clear reads zero");

        // R3 load and prescaler restart; R2 step per CLK_HZ cycles
        apb_write(12'h008, 32'h1000_0000);
        idle(7);
        apb_read(12'h000, 32'h1000_0000, "R3 before first tick");
        apb_read(12'h000, 32'h1000_0001, "R3 after first tick");
        apb_read(12'h008, 32'h1000_0000, "R3 loaded readback");
        apb_write(12'h008, 32'h0000_2000);
        idle(8);
        apb_read(12'h000, 32'h0000_2001, "R3 tick exactly CLK_HZ after load");
        apb_write(12'h008, 32'h0000_0050);
        idle(28);
        apb_read(12'h000, 32'h0000_0053, "R2 three seconds");

        // R6 alarm on tick
        apb_write(12'h008, 32'h0000_0100);
        apb_write(12'h004, 32'h0000_0101);
        idle(4);
        apb_read(12'h014, 32'h0, "R6 raw before tick");
        apb_read(12'h014, 32'h1, "R6 raw after tick");
        apb_read(12'h018, 32'h0, "R7 masked with mask off");
        check_irq(1'b0, "R7 mask off");

        // R7 mask bit 0 only
        apb_write(12'h010, 32'hFFFF_FFFE);
        apb_read(12'h010, 32'h0, "R7 mask upper bits dropped");
        check_irq(1'b0, "R7 mask zero");
        apb_write(12'h010, 32'h0000_0003);
        apb_read(12'h010, 32'h1, "R7 mask bit0");
        apb_read(12'h018, 32'h1, "R7 masked on");
        check_irq(1'b1, "R7 irq on");

        // R8 clear with zero data
        apb_write(12'h01C, 32'h0);
        apb_read(12'h014, 32'h0, "R8 raw cleared");
        apb_read(12'h018, 32'h0, "R8 masked cleared");
        check_irq(1'b0, "R8 irq cleared");

        // R5 immediate fire on match write and on load write
        apb_write(12'h008, 32'h0000_5000);
        apb_write(12'h004, 32'h0000_5000);
        apb_read(12'h014, 32'h1, "R5 match write equal");
        check_irq(1'b1, "R5 irq");
        apb_write(12'h01C, 32'hFFFF_FFFF);
        apb_read(12'h014, 32'h0, "R8 clear all-ones data");
        apb_write(12'h008, 32'h0000_5000);
        apb_read(12'h014, 32'h1, "R5 load write equal");
        apb_write(12'h01C, 32'h0000_0001);

        // R10 writes to read-only locations ignored
        apb_write(12'h008, 32'h0000_7777);
        apb_write(12'h000, 32'h0000_DEAD);
        apb_read(12'h000, 32'h0000_7777, "R10 count write ignored");
        apb_write(12'h014, 32'hFFFF_FFFF);
        apb_read(12'h014, 32'h0, "R10 raw write ignored");
        apb_write(12'h018, 32'h0000_0001);
        apb_read(12'h018, 32'h0, "R10 masked write ignored");
        apb_read(12'h008, 32'h0000_7777, "R10 loaded untouched");

        // R4 wrap with match below count
        apb_write(12'h008, 32'hFFFF_FFFF);
        apb_write(12'h004, 32'h0000_0000);
        idle(4);
        apb_read(12'h014, 32'h0, "R4 no fire before wrap");
        apb_read(12'h014, 32'h1, "R4 fire after wrap");
        apb_read(12'h000, 32'h0, "R4 count wrapped");

        idle(3);
        if (exp_q.size() != 0) begin
            checks++;
            failures++;
            $display("FAIL scoreboard left=%0d expected=0", exp_q.size());
        end
        finish_run();
    end

endmodule